// File: doc/BRIEF.md
# Iterative Reciprocal Square Root Unit

The unit takes one positive single-precision float and returns an approximation of its reciprocal square root. It gets a first estimate without arithmetic: it treats the input bits as an unsigned integer, halves that integer with a right shift, and subtracts the result from a fixed constant. It then improves the estimate by a chosen number of Newton-Raphson refinement passes. A pass computes `y * (1.5 - (x/2) * y * y)`.

The passes run one after another on a single shared truncating float multiplier and one fixed-point subtract stage, so a pass takes four clock cycles. Both handshakes use a valid and ready pair. Only one operation is in flight at a time. A request carries the operand and a pass count from 0 to 3. Operands that cannot be handled skip the passes and return a flagged quiet NaN.

Top module: `rsqrt_unit`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1.
- R2: An operand whose bit 31 (sign) is 1, or whose exponent field (bits 30:23) is 0 or 255, is invalid. The result is then 0x7FC00000 with `out_invalid` = 1, and it is presented one cycle after acceptance without running any pass.
- R3: With `in_iters` = 0 and a valid operand, the result is the 32-bit difference SEED_MAGIC (default 0x5F3759DF) minus the operand shifted right by one bit. It is presented one cycle after acceptance with `out_invalid` = 0.
- R4: With `in_iters` = n > 0, `out_valid` rises 1 + 4n cycles after the accepting edge.
- R5: Each pass computes s = y*y, then t = h*s, then r = 1.5 - t, then y = y*r, in that order. The float product of two operands with nonzero exponent is formed as follows. The 24-bit significands (hidden bit included) are multiplied. The product is normalised, and its lower bits are cut off. The exponent is ea + eb - 127, plus 1 if the product reached 2.0. The result is 0 if either exponent field is 0 or if the exponent is 0 or less. It is 0x7F7FFFFF if the exponent is 255 or more.
- R6: The value 1.5 - t is formed in fixed point with 23 fraction bits. t is aligned by a truncating right shift. The result is 0 when t is 1.5 or more, and it is renormalised to a float otherwise.
- R7: The half-operand h is the operand with its exponent field reduced by 1, and it does not use the multiplier. An operand with exponent field 1 gives h = 0.
- R8: While a request is being processed, and while `out_valid` is 1, `in_ready` is 0 and `in_valid` has no effect. `out_valid` and `out_data` hold until `out_ready` is 1, and the unit takes a new request on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to accept |
| in_data | input | 32 | Operand bits, single precision |
| in_iters | input | ITER_W | Number of refinement passes (0 to 3 by default) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result bits, single precision |
| out_invalid | output | 1 | Operand was rejected and the result is a NaN |

## Verification
The bench builds the unit with its default parameters: a two-bit pass count and the standard magic constant. This lets it reach every pass count from 0 to 3 and therefore every latency the sequencer can produce. The operands cover powers of four, the smallest and largest normals, and a spread of pseudo-random values. They also include every invalid class: a set sign bit, a zero exponent, a denormal, infinity and NaN. The smallest normal drives the half-operand flush. Pseudo-random back-pressure on `out_ready` exercises result holding, and extra words on `in_valid` while the unit is busy show that it ignores them.

// File: rtl/rsqrt_unit.sv
module rsqrt_unit #(
  parameter int          ITER_W     = 2,
  parameter logic [31:0] SEED_MAGIC = 32'h5F3759DF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic [ITER_W-1:0] in_iters,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              out_invalid
);
  localparam logic [31:0] QNAN    = 32'h7FC00000;
  localparam logic [31:0] FLT_MAX = 32'h7F7FFFFF;
  localparam logic [24:0] ONE_P5  = 25'h0C00000;

  typedef enum logic [2:0] {S_IDLE, S_SQ, S_T, S_SUB, S_UPD, S_DONE} st_t;

  st_t               state;
  logic [31:0]       y, hx, tmp;
  logic [ITER_W-1:0] cnt;
  logic              bad;

  wire in_bad = in_data[31] || (in_data[30:23] == 8'd0) || (in_data[30:23] == 8'hFF);

  // shared multiplier operand select
  logic [31:0] mul_a, mul_b, mul_y;
  assign mul_a = (state == S_T) ? hx : y;
  assign mul_b = (state == S_SQ) ? y : tmp;

  logic [47:0]       prod;
  logic signed [9:0] pe;
  logic [22:0]       pm;
  always_comb begin
    prod = 48'({1'b1, mul_a[22:0]}) * 48'({1'b1, mul_b[22:0]});
    pe   = 10'(mul_a[30:23]) + 10'(mul_b[30:23]) - 10'sd127 + 10'(prod[47]);
    pm   = prod[47] ? prod[46:24] : prod[45:23];
    if (mul_a[30:23] == 8'd0 || mul_b[30:23] == 8'd0 || pe <= 10'sd0)
      mul_y = 32'd0;
    else if (pe >= 10'sd255)
      mul_y = FLT_MAX;
    else
      mul_y = {1'b0, pe[7:0], pm};
  end

  // 1.5 - tmp in fixed point
  logic [23:0] tu;
  logic [24:0] dif;
  logic [4:0]  msb;
  logic [23:0] nrm;
  logic [31:0] sub_y;
  always_comb begin
    if (tmp[30:23] == 8'd0 || tmp[30:23] > 8'd127)
      tu = 24'd0;
    else
      tu = {1'b1, tmp[22:0]} >> (8'd127 - tmp[30:23]);
    dif = ONE_P5 - {1'b0, tu};
    msb = 5'd0;
    for (int i = 0; i < 24; i++)
      if (dif[i]) msb = 5'(i);
    nrm = dif[23:0] << (5'd23 - msb);
    if (tmp[30:23] > 8'd127 || dif[24] || dif == 25'd0)
      sub_y = 32'd0;
    else
      sub_y = {1'b0, 8'd104 + 8'(msb), nrm[22:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      y     <= '0;
      hx    <= '0;
      tmp   <= '0;
      cnt   <= '0;
      bad   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          y     <= in_bad ? QNAN : SEED_MAGIC - (in_data >> 1);
          hx    <= (in_data[30:23] <= 8'd1) ? 32'd0
                 : {1'b0, in_data[30:23] - 8'd1, in_data[22:0]};
          cnt   <= in_iters;
          bad   <= in_bad;
          state <= (in_bad || in_iters == '0) ? S_DONE : S_SQ;
        end
        S_SQ:  begin tmp <= mul_y; state <= S_T;   end
        S_T:   begin tmp <= mul_y; state <= S_SUB; end
        S_SUB: begin tmp <= sub_y; state <= S_UPD; end
        S_UPD: begin
          y     <= mul_y;
          cnt   <= cnt - 1'b1;
          state <= (cnt == ITER_W'(1)) ? S_DONE : S_SQ;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign in_ready    = (state == S_IDLE);
  assign out_valid   = (state == S_DONE);
  assign out_data    = y;
  assign out_invalid = bad;
endmodule

// File: rtl/rsqrt_unit_chk.sv
module rsqrt_unit_chk #(
  parameter int ITER_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_data,
  input logic [ITER_W-1:0] in_iters,
  input logic              out_valid,
  input logic              out_ready,
  input logic [31:0]       out_data,
  input logic              out_invalid
);
  wire bad_in = in_data[31] || (in_data[30:23] == 8'd0) || (in_data[30:23] == 8'hFF);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  p_reject_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && bad_in |=> out_valid && out_invalid);

  p_nan_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_data == 32'h7FC00000);

  p_zero_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_iters == '0 |=> out_valid);

  p_pass_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_iters != '0 && !bad_in |=> !out_valid);

  p_ready_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_invalid));
endmodule

bind rsqrt_unit rsqrt_unit_chk #(.ITER_W(ITER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_iters(in_iters), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_invalid(out_invalid)
);

// File: tb/rsqrt_unit_test.sv
`timescale 1ns/1ps
module rsqrt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [1:0]  in_iters = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_invalid;

  always #5 clk = ~clk;

  rsqrt_unit uut (.*);

  int checks = 0, fails = 0;
  bit bp_mode = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference arithmetic, integer based
  function automatic logic [31:0] ref_mul(logic [31:0] a, logic [31:0] b);
    longint p, ma, mb;
    int e;
    if (a[30:23] == 0 || b[30:23] == 0) return 0;
    ma = 64'h800000 + a[22:0];
    mb = 64'h800000 + b[22:0];
    p  = ma * mb;
    e  = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p >= (64'd1 << 47)) begin p = p >>> 24; e = e + 1; end
    else p = p >>> 23;
    if (e <= 0) return 0;
    if (e >= 255) return 32'h7F7FFFFF;
    return {1'b0, 8'(e), 23'(p)};
  endfunction

  function automatic logic [31:0] ref_sub(logic [31:0] t);
    longint tv, d;
    int e, p;
    e = int'(t[30:23]);
    if (e > 127) return 0;
    if (e == 0) tv = 0;
    else if (127 - e >= 24) tv = 0;
    else tv = (64'h800000 + t[22:0]) >>> (127 - e);
    d = 64'hC00000 - tv;
    if (d <= 0) return 0;
    p = 23;
    while (((d >>> p) & 1) == 0) p--;
    d = (d << (23 - p)) & 64'h7FFFFF;
    return {1'b0, 8'(127 + p - 23), 23'(d)};
  endfunction

  function automatic logic [31:0] ref_rsqrt(logic [31:0] x, int n);
    logic [31:0] y, h, s, t, r;
    y = 32'h5F3759DF - (x >> 1);
    h = (x[30:23] <= 1) ? 32'd0 : x - 32'h00800000;   // R7
    for (int k = 0; k < n; k++) begin
      s = ref_mul(y, y);
      t = ref_mul(h, s);
      r = ref_sub(t);                                  // R6
      y = ref_mul(y, r);                               // R5
    end
    return y;
  endfunction

  // cycle model
  bit          m_busy = 0, m_done = 0, m_inv = 0;
  int          m_wait = 0;
  logic [31:0] m_res = 0;
  string       m_tag = "R3";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0;
    end else if (m_done) begin
      if (out_ready) m_done = 0;
    end else if (m_busy) begin
      m_wait--;
      if (m_wait == 0) begin m_busy = 0; m_done = 1; end
    end else if (in_valid) begin
      m_inv = in_data[31] || in_data[30:23] == 0 || in_data[30:23] == 8'hFF;
      if (m_inv) begin
        m_res = 32'h7FC00000; m_tag = "R2"; m_done = 1;
      end else begin
        m_res = ref_rsqrt(in_data, int'(in_iters));
        if (in_iters == 0) begin m_tag = "R3"; m_done = 1; end
        else begin m_tag = "R5"; m_busy = 1; m_wait = 4 * int'(in_iters); end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        checks++;
        if (out_valid !== 1'b0) begin
          fails++; $display("FAIL R1 reset out_valid=%b expected 0", out_valid);
        end
      end else begin
        checks++;
        if (in_ready !== !(m_busy || m_done)) begin
          fails++; $display("FAIL R8 in_ready=%b expected %b", in_ready, !(m_busy || m_done));
        end
        checks++;
        if (out_valid !== m_done) begin
          fails++; $display("FAIL R4 out_valid=%b expected %b", out_valid, m_done);
        end
        if (m_done && out_valid) begin
          checks++;
          if (out_data !== m_res || out_invalid !== m_inv) begin
            fails++;
            $display("FAIL %s out_data=%h inv=%b expected %h inv=%b",
                     m_tag, out_data, out_invalid, m_res, m_inv);
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_mode ? lfsr[0] : 1'b1;
    end
  end

  task automatic send(logic [31:0] x, logic [1:0] n, bit noise);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    #1;
    in_valid = 1; in_data = x; in_iters = n;
    @(negedge clk); #1;
    if (noise) begin
      // R8: junk offered while busy must be ignored
      in_data = 32'h3F800000 ^ {9'd0, lfsr, 7'd0};
      in_iters = 2'd3;
      while (!out_valid) begin @(negedge clk); #1; end
    end
    in_valid = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    logic [31:0] vals [12];
    logic [31:0] bads [6];
    logic [31:0] r;
    vals = '{32'h3F800000, 32'h40800000, 32'h41800000, 32'h40000000,
             32'h3E800000, 32'h7F7FFFFF, 32'h00800000, 32'h40400000,
             32'h501502F9, 32'h00FFFFFF, 32'h3F7FFFFF, 32'h42C80000};
    bads = '{32'hBF800000, 32'h00000000, 32'h00000001, 32'h7F800000,
             32'h7FC00000, 32'h80000000};
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // R1 idle after reset
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b1) begin
      fails++; $display("FAIL R1 in_ready=%b expected 1", in_ready);
    end
    // R3 R4 R5 R6 R7 fixed operands, all pass counts
    for (int n = 0; n < 4; n++)
      foreach (vals[i]) send(vals[i], 2'(n), 0);
    // R2 invalid classes
    for (int n = 0; n < 4; n++)
      foreach (bads[i]) send(bads[i], 2'(n), 0);
    // R8 with back-pressure and busy junk
    bp_mode = 1;
    for (int k = 0; k < 40; k++) begin
      r = {1'b0, lfsr, lfsr[14:0]};
      if (r[30:23] == 0) r[23] = 1'b1;
      send(r, 2'(k), k % 3 == 0);
    end
    for (int k = 0; k < 120; k++) begin
      r = {1'b0, 8'(k + 1), lfsr[6:0], lfsr};
      send(r, 2'(k), 0);
    end
    bp_mode = 0;
    repeat (20) @(negedge clk);
    summary();
  end

  initial begin
    #2000000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule